// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked synchronous serial link in which the shift clock is supplied from outside. A host bus or a transfer engine writes a byte into a holding register. When the shifter is idle, the transmitter is enabled and the empty flag has been cleared, the byte moves into the shifter. It is then sent least significant bit first, with one bit for each falling edge of the external clock. That clock is an asynchronous input. It passes through a synchronizer and its falling edges are found with the system clock.

The empty flag carries the flow control. It is set each time the holding register is moved into the shifter. It can be cleared in two ways. Software reads the status register while the flag is set and then writes 0 to that bit. Alternatively, a transfer-engine write clears it, but only when the engine reports that it is not disabling itself at the end of the transfer and that its remaining count is non-zero. The block also enforces a guard time. The first shift edge of a frame must arrive at least five system clocks after the holding register was last written. An earlier edge is dropped and reported. A stop/standby request returns the whole block to its reset state.

Top module: `cs_serial_tx`

## Requirements
- R1: Each byte leaves on `txd` least significant bit first. The first accepted falling edge of `sclk_in` drives bit 0, and each following accepted falling edge drives the next bit. After bit 7, one further accepted falling edge ends the frame and returns `txd` to 1.
- R2: After reset, `txd` is 1 and the registers read as follows. Status (address 1) reads 0x03: bit 0 is the empty flag and bit 1 is the end flag. Control (address 2) reads 0x00. Data (address 0) reads 0x00. Both interrupt outputs are 0.
- R3: A status write with bit 0 equal to 0 clears the empty flag only if a status read that saw the flag set came first. Any status write cancels that read. Without the read, the write leaves the status unchanged. Clearing the empty flag also clears the end flag.
- R4: A transfer-engine write always loads the data register. It clears the empty flag only when `eng_dis_on_end` is 0 and `eng_count_nz` is 1. In every other case the flag stays set.
- R5: The guard time is checked on the first falling edge of a frame. If that edge is detected fewer than 5 system clocks after the last data-register write, it is ignored, `txd` keeps its value, and `guard_err` pulses for one cycle.
- R6: A byte is loaded when the shifter is idle, control bit 0 (transmit enable) is 1 and the empty flag is 0. The load sets the empty flag. If control bit 1 is 1, the load also produces a one-cycle `irq_empty` pulse.
- R7: The end flag is set when a frame finishes while the empty flag is 1. `irq_end` is the end flag ANDed with control bit 2.
- R8: While transmit enable is 0, `txd` is 1, falling edges of `sclk_in` have no effect, and no byte is loaded.
- R9: While `stop_req` is 1, the data, status, control and shift state return to their reset values. A frame in progress is abandoned and `txd` goes to 1.
- R10: If the empty flag is cleared during a frame, the new byte is loaded when that frame ends. No end flag is raised in that case.
- R11: After a stop, nothing is shifted until transmit enable is set again and the status-read-then-clear sequence has been repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Module-stop / standby request, level |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| eng_wr | input | 1 | Transfer-engine data write strobe |
| eng_data | input | 8 | Transfer-engine write data |
| eng_dis_on_end | input | 1 | Engine disables itself at transfer end |
| eng_count_nz | input | 1 | Engine transfer count is non-zero |
| sclk_in | input | 1 | External shift clock, asynchronous |
| txd | output | 1 | Serial data output, idles high |
| irq_empty | output | 1 | Data-register-empty interrupt pulse |
| irq_end | output | 1 | Transmit-end interrupt level |
| guard_err | output | 1 | Guard-time violation pulse |

## Verification
The assertions assume several things about the inputs. `stop_req` is a clean level that is held for at least one clock. Host and engine strobes are never asserted in the same cycle as each other. `sclk_in` changes slowly enough that the synchronizer sees every level for several system clocks. The stimulus drives every input on the falling edge of `clk` and keeps each strobe high for exactly one cycle. It holds each shift-clock phase for eight system clocks, and it asserts `stop_req` only while `sclk_in` is high. Shift edges arrive either well outside the five-clock guard window or, in the one test aimed at the guard, two clocks after an engine write.

// File: rtl/cs_serial_tx_pkg.sv
package cs_serial_tx_pkg;

    // register select values on the host port
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    // status bit positions
    localparam int ST_EMPTY = 0;
    localparam int ST_END   = 1;

    // control bit positions
    localparam int CT_EN    = 0;
    localparam int CT_EIE   = 1;
    localparam int CT_ENDIE = 2;

endpackage

// File: rtl/cs_sclk_sync.sv
module cs_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic fall
);
    // sh_q[0..STAGES-1] synchronize, sh_q[STAGES] holds the previous level
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sclk_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/cs_tx_regs.sv
module cs_tx_regs
    import cs_serial_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int GUARD_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_wr,
    input  logic [DATA_W-1:0] eng_data,
    input  logic              eng_dis_on_end,
    input  logic              eng_count_nz,
    input  logic              load,
    input  logic              frame_done,
    output logic [DATA_W-1:0] tx_data,
    output logic              tde,
    output logic              tend,
    output logic              txen,
    output logic              tie,
    output logic              teie,
    output logic              guard_ok
);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] GUARD_MAX = GW'(GUARD_CYC);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              tde;
        logic              tend;
        logic              armed;
        logic              txen;
        logic              tie;
        logic              teie;
        logic [GW-1:0]     guard;
    } regs_t;

    localparam regs_t RST = '{
        data:  '0,
        tde:   1'b1,
        tend:  1'b1,
        armed: 1'b0,
        txen:  1'b0,
        tie:   1'b0,
        teie:  1'b0,
        guard: GUARD_MAX
    };

    regs_t d, q;
    logic  clr;
    logic  unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:3];

    always_comb begin
        d   = q;
        clr = 1'b0;

        if (q.guard != GUARD_MAX) d.guard = q.guard + 1'b1;

        if (reg_wr) begin
            case (reg_addr)
                SEL_DATA: begin
                    d.data  = reg_wdata;
                    d.guard = '0;
                end
                SEL_STAT: begin
                    d.armed = 1'b0;
                    if (q.armed && !reg_wdata[ST_EMPTY]) clr = 1'b1;
                end
                SEL_CTRL: begin
                    d.txen = reg_wdata[CT_EN];
                    d.tie  = reg_wdata[CT_EIE];
                    d.teie = reg_wdata[CT_ENDIE];
                end
                default: ;
            endcase
        end

        if (eng_wr) begin
            d.data  = eng_data;
            d.guard = '0;
            if (!eng_dis_on_end && eng_count_nz) clr = 1'b1;
        end

        if (reg_rd && !reg_wr && (reg_addr == SEL_STAT) && q.tde) d.armed = 1'b1;

        if (frame_done && q.tde) d.tend = 1'b1;

        if (clr) begin
            d.tde  = 1'b0;
            d.tend = 1'b0;
        end

        if (load) d.tde = 1'b1;

        if (stop_req) d = RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_DATA: reg_rdata = q.data;
            SEL_STAT: begin
                reg_rdata[ST_EMPTY] = q.tde;
                reg_rdata[ST_END]   = q.tend;
            end
            SEL_CTRL: begin
                reg_rdata[CT_EN]    = q.txen;
                reg_rdata[CT_EIE]   = q.tie;
                reg_rdata[CT_ENDIE] = q.teie;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign tx_data  = q.data;
    assign tde      = q.tde;
    assign tend     = q.tend;
    assign txen     = q.txen;
    assign tie      = q.tie;
    assign teie     = q.teie;
    assign guard_ok = (q.guard == GUARD_MAX);
endmodule

// File: rtl/cs_tx_shifter.sv
module cs_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              fall,
    input  logic              txen,
    input  logic              tde,
    input  logic              guard_ok,
    input  logic [DATA_W-1:0] tx_data,
    output logic              load,
    output logic              frame_done,
    output logic              guard_err,
    output logic              txd
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              txd;
    } shf_t;

    localparam shf_t RST = '{active: 1'b0, shreg: '0, cnt: '0, txd: 1'b1};

    shf_t d, q;
    logic edge_ok, first, acc;

    always_comb begin
        edge_ok    = fall && txen && q.active && !stop_req;
        first      = (q.cnt == '0);
        guard_err  = edge_ok && first && !guard_ok;
        acc        = edge_ok && !(first && !guard_ok);
        frame_done = acc && (q.cnt == LAST);
        load       = !q.active && txen && !tde && !stop_req;

        d = q;
        if (load) begin
            d.active = 1'b1;
            d.shreg  = tx_data;
            d.cnt    = '0;
        end
        if (acc) begin
            if (q.cnt == LAST) begin
                d.txd    = 1'b1;
                d.active = 1'b0;
            end else begin
                d.txd   = q.shreg[0];
                d.shreg = q.shreg >> 1;
                d.cnt   = q.cnt + 1'b1;
            end
        end
        if (!txen) begin
            d.active = 1'b0;
            d.txd    = 1'b1;
        end
        if (stop_req) d = RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign txd = q.txd;
endmodule

// File: rtl/cs_serial_tx.sv
module cs_serial_tx #(
    parameter int DATA_W      = 8,
    parameter int GUARD_CYC   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_wr,
    input  logic [DATA_W-1:0] eng_data,
    input  logic              eng_dis_on_end,
    input  logic              eng_count_nz,
    input  logic              sclk_in,
    output logic              txd,
    output logic              irq_empty,
    output logic              irq_end,
    output logic              guard_err
);
    typedef struct packed {
        logic irq_empty;
    } top_t;

    top_t d, q;

    logic              fall_w, load_w, done_w;
    logic [DATA_W-1:0] data_w;
    logic              tde_w, tend_w, txen_w, tie_w, teie_w, gok_w;

    cs_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .fall    (fall_w)
    );

    cs_tx_regs #(.DATA_W(DATA_W), .GUARD_CYC(GUARD_CYC)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .stop_req       (stop_req),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .eng_wr         (eng_wr),
        .eng_data       (eng_data),
        .eng_dis_on_end (eng_dis_on_end),
        .eng_count_nz   (eng_count_nz),
        .load           (load_w),
        .frame_done     (done_w),
        .tx_data        (data_w),
        .tde            (tde_w),
        .tend           (tend_w),
        .txen           (txen_w),
        .tie            (tie_w),
        .teie           (teie_w),
        .guard_ok       (gok_w)
    );

    cs_tx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (stop_req),
        .fall       (fall_w),
        .txen       (txen_w),
        .tde        (tde_w),
        .guard_ok   (gok_w),
        .tx_data    (data_w),
        .load       (load_w),
        .frame_done (done_w),
        .guard_err  (guard_err),
        .txd        (txd)
    );

    always_comb begin
        d.irq_empty = load_w && tie_w && !stop_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_empty = q.irq_empty;
    assign irq_end   = tend_w & teie_w;
endmodule

// File: rtl/cs_serial_tx_chk.sv
module cs_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic txen,
    input logic tde,
    input logic txd,
    input logic guard_err,
    input logic irq_empty,
    input logic irq_end
);
    // R8: disabled transmitter keeps the line high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!txen && $past(!txen)) |-> txd);

    // R9: a stop request returns flag, enable and line to reset values
    a_r9_stop_resets: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (tde && txd && !txen));

    // R5: a rejected edge leaves the line untouched
    a_r5_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_err && !stop_req) |=> $stable(txd));

    // R6: the empty interrupt follows a load, which sets the flag
    a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> tde);

    // R7: the end interrupt only with the empty flag set
    a_r7_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |-> tde);
endmodule

bind cs_serial_tx cs_serial_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .txen      (txen_w),
    .tde       (tde_w),
    .txd       (txd),
    .guard_err (guard_err),
    .irq_empty (irq_empty),
    .irq_end   (irq_end)
);

// File: tb/cs_serial_tx_bench.sv
module cs_serial_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       eng_wr = 1'b0;
    logic [7:0] eng_data = 8'h00;
    logic       eng_dis_on_end = 1'b0;
    logic       eng_count_nz = 1'b0;
    logic       sclk_in = 1'b1;
    logic       txd, irq_empty, irq_end, guard_err;

    always #2 clk = ~clk;

    cs_serial_tx u_cs_serial_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .stop_req       (stop_req),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .eng_wr         (eng_wr),
        .eng_data       (eng_data),
        .eng_dis_on_end (eng_dis_on_end),
        .eng_count_nz   (eng_count_nz),
        .sclk_in        (sclk_in),
        .txd            (txd),
        .irq_empty      (irq_empty),
        .irq_end        (irq_end),
        .guard_err      (guard_err)
    );

    int   checks = 0;
    int   errors = 0;
    int   n_empty = 0;
    int   n_gerr = 0;
    bit   done = 1'b0;
    logic exp_q[$];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && irq_empty) n_empty++;
        if (rst_n && guard_err) n_gerr++;
    end

    // monitor: scoreboard of expected line values, one per shift pulse
    initial forever begin
        @(negedge sclk_in);
        repeat (6) @(negedge clk);
        if (exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            chk("R1 txd bit", int'(txd), int'(e));
        end
    end

    task automatic pulse(logic e);
        exp_q.push_back(e);
        @(negedge clk) sclk_in = 1'b0;
        repeat (8) @(negedge clk);
        sclk_in = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bits(logic [7:0] b, bit skip_first);
        if (skip_first) pulse(1'b1);
        for (int i = 0; i < 8; i++) pulse(b[i]);
        pulse(1'b1);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng(logic [7:0] v, logic dis, logic nz);
        @(negedge clk);
        eng_wr = 1'b1; eng_data = v; eng_dis_on_end = dis; eng_count_nz = nz;
        @(negedge clk);
        eng_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int base;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R2 reset state
        chk("R2 txd", int'(txd), 1);
        rd(2'd1, v); chk("R2 status", int'(v), 'h03);
        rd(2'd2, v); chk("R2 control", int'(v), 'h00);
        rd(2'd0, v); chk("R2 data", int'(v), 'h00);
        chk("R2 irq", int'({irq_empty, irq_end}), 0);

        // R3 write without prior read has no effect
        wr(2'd1, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R3 unarmed clear ignored", int'(v), 'h03);

        // R3 read then write clears (transmitter still disabled)
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R3 armed clear", int'(v), 'h00);

        // R8 disabled: edges ignored, nothing loaded
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        chk("R8 no load while disabled", n_empty, 0);
        rd(2'd1, v); chk("R8 status unchanged", int'(v), 'h00);

        // R6 enable loads the waiting byte
        wr(2'd2, 8'h07);
        idle(3);
        chk("R6 irq_empty pulse", n_empty, 1);
        rd(2'd1, v); chk("R6 flag set by load", int'(v), 'h01);
        send_bits(8'h5A, 1'b0);
        idle(4);
        rd(2'd1, v); chk("R7 end flag", int'(v), 'h03);
        chk("R7 irq_end high", int'(irq_end), 1);

        // R4 engine write with auto clear
        eng(8'h3C, 1'b0, 1'b1);
        idle(10);
        chk("R7 irq_end cleared", int'(irq_end), 0);
        send_bits(8'h3C, 1'b0);
        chk("R4 engine load count", n_empty, 2);

        // R4 engine write with disable-on-end: flag stays
        eng(8'hC3, 1'b1, 1'b1);
        idle(2);
        rd(2'd1, v); chk("R4 dis keeps flag", int'(v), 'h03);
        rd(2'd0, v); chk("R4 data updated", int'(v), 'hC3);
        pulse(1'b1); pulse(1'b1);
        wr(2'd1, 8'h00);
        idle(10);
        send_bits(8'hC3, 1'b0);

        // R4 engine write with zero count: flag stays
        eng(8'h99, 1'b0, 1'b0);
        idle(2);
        rd(2'd1, v); chk("R4 zero count keeps flag", int'(v), 'h03);
        rd(2'd0, v); chk("R4 data updated zero count", int'(v), 'h99);
        wr(2'd1, 8'h00);
        idle(10);
        send_bits(8'h99, 1'b0);

        // R5 early edge after engine write is rejected
        base = n_gerr;
        eng(8'h6E, 1'b0, 1'b1);
        send_bits(8'h6E, 1'b1);
        chk("R5 guard_err count", n_gerr - base, 1);

        // R10 chained frames
        base = n_empty;
        wr(2'd0, 8'h81);
        rd(2'd1, v);
        wr(2'd1, 8'h00);
        idle(10);
        fork
            begin
                send_bits(8'h81, 1'b0);
                send_bits(8'h7E, 1'b0);
            end
            begin
                logic [7:0] t;
                idle(40);
                wr(2'd0, 8'h7E);
                rd(2'd1, t);
                wr(2'd1, 8'h00);
            end
        join
        idle(4);
        chk("R10 two loads", n_empty - base, 2);
        rd(2'd1, v); chk("R10 end after second frame", int'(v), 'h03);

        // R9 stop mid-frame
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'h00);
        idle(10);
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        @(negedge clk) stop_req = 1'b1;
        idle(4);
        stop_req = 1'b0;
        idle(2);
        chk("R9 txd high", int'(txd), 1);
        rd(2'd1, v); chk("R9 status reset", int'(v), 'h03);
        rd(2'd2, v); chk("R9 control reset", int'(v), 'h00);
        rd(2'd0, v); chk("R9 data reset", int'(v), 'h00);
        pulse(1'b1);

        // R11 resume needs enable plus read/clear
        wr(2'd0, 8'h2D);
        wr(2'd2, 8'h07);
        idle(3);
        rd(2'd1, v); chk("R11 no load before clear", int'(v), 'h03);
        pulse(1'b1);
        wr(2'd1, 8'h00);
        idle(10);
        send_bits(8'h2D, 1'b0);
        idle(20);
        chk("R1 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule